// File: doc/BRIEF.md
# TDM Serial Port Frame Sequencer

This block is the slave side of a time-division-multiplexed serial link between a codec core and an external signal processor. It runs directly on the serial bit clock. Each frame is twelve 16-bit slots long. The block raises a one-clock frame sync at the start of every frame. It shifts twelve parallel outgoing words onto the serial output, most significant bit first. At the same time it collects twelve incoming words from the serial input. The twelve incoming words appear as parallel outputs, and a one-clock strobe marks when the whole set is fresh.

Slot 0 carries status out and control in. Slot 1 carries register read data out and register write data in. Slots 2 to 11 hold right/left sample pairs in this order: capture, playback, synth, auxiliary port 1, auxiliary port 0.

By default frames follow each other with no gap. A 3-bit rate select can tie the frame rate to one of five external rate-tick sources instead. In that mode the port sits idle after the last slot until the selected source ticks. Because of this, the number of idle clocks between frames can change from one frame to the next.

Top module: `tdm_frame_seq`

## Requirements
- R1: While reset is held, `fsync`, `sdo` and `frame_done` are 0 and every bit of `rx_words` is 0. With rate select 0, the first frame sync is high in the bit clock that follows the first rising edge after reset is released.
- R2: A frame lasts 192 bit clocks. At the maximum rate, each frame sync comes exactly 192 clocks after the previous one, with no idle clock in between.
- R3: `fsync` is high for exactly one bit clock, and that clock is bit 0 of slot 0.
- R4: In slot s, `sdo` carries `tx_words[16*s+15:16*s]`, most significant bit first. It changes on rising edges. The word for a slot is taken from `tx_words` on the rising edge that begins that slot.
- R5: `sdi` is sampled on falling edges, most significant bit first. The word received in slot s is placed in `rx_words[16*s+15:16*s]`. `frame_done` is high for one clock, in the clock after the last bit of slot 11, and at that time all twelve words belong to the frame just ended.
- R6: Rate select encoding: 0 is the maximum rate. Values 1 to 5 select tick sources `rate_tick[0]` to `rate_tick[4]`, which are capture, playback, synth, auxiliary port 1 and auxiliary port 0 in that order. Values 6 and 7 behave like 0.
- R7: With a tick source selected, the port goes idle after the 192nd bit. While idle, `fsync` stays low. A new frame begins, with `fsync` high, in the clock after the first rising edge at which the port is idle and the selected tick is high.
- R8: A tick from a source that is not selected has no effect. A tick seen while a frame is running, including on its final bit, also has no effect.
- R9: `sdo` is 0 during every idle clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rate_sel | input | 3 | Frame rate choice |
| rate_tick | input | 5 | Rate tick pulses, one per source, synchronous to clk |
| tx_words | input | 192 | Outgoing words, slot s in bits 16*s+15:16*s |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| fsync | output | 1 | Frame sync pulse |
| rx_words | output | 192 | Captured words, slot s in bits 16*s+15:16*s |
| frame_done | output | 1 | All received words of the last frame are valid |

## Verification
The bench runs frames back to back at the maximum rate and compares every output bit and every captured word. An off-by-one in the slot counter or a stray idle clock would shift the sync away from 192 clocks or mangle the last slot. The bench then switches to tick-driven rates and checks several ways a frame could start wrongly: a tick from an unselected source, a tick in the middle of a frame, and a tick on the very last bit. A design that accepted any of these would begin a frame too early, and a design that did not clear its output shifter would drive stray ones while idle. Finally, the reserved select value 6 must chain frames the same way the maximum rate does.

// File: rtl/tdm_frame_seq.sv
module tdm_frame_seq #(
  parameter int SLOT_W = 16,
  parameter int SLOTS  = 12,
  parameter int NRATE  = 5,
  parameter int SEL_W  = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [SEL_W-1:0]           rate_sel,
  input  logic [NRATE-1:0]           rate_tick,
  input  logic [SLOT_W*SLOTS-1:0]    tx_words,
  input  logic                       sdi,
  output logic                       sdo,
  output logic                       fsync,
  output logic [SLOT_W*SLOTS-1:0]    rx_words,
  output logic                       frame_done
);

  localparam int FRAME_LEN = SLOT_W * SLOTS;
  localparam int CNT_W     = $clog2(FRAME_LEN);
  localparam int BIT_W     = $clog2(SLOT_W);
  localparam int SLOT_IW   = CNT_W - BIT_W;

  logic              active;
  logic [CNT_W-1:0]  cnt;
  logic [SLOT_W-1:0] tx_sh;
  logic [SLOT_W-2:0] rx_sh;
  logic              done_q;
  logic              sel_max, tick_sel, last, start;
  logic [SLOT_IW-1:0] slot_idx;
  logic [BIT_W-1:0]   bit_idx;
  logic [SLOT_W-1:0]  nxt_word;

  assign slot_idx = cnt[CNT_W-1:BIT_W];
  assign bit_idx  = cnt[BIT_W-1:0];
  assign last     = active && (cnt == CNT_W'(FRAME_LEN-1));

  always_comb begin
    sel_max  = 1'b1;
    tick_sel = 1'b0;
    for (int i = 0; i < NRATE; i++) begin
      if (rate_sel == SEL_W'(i+1)) begin
        sel_max  = 1'b0;
        tick_sel = rate_tick[i];
      end
    end
  end

  assign start = (!active && (sel_max || tick_sel)) || (last && sel_max);
  assign nxt_word = (int'(slot_idx) + 1 < SLOTS) ?
                    tx_words[SLOT_W*(int'(slot_idx)+1) +: SLOT_W] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      tx_sh  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= last;
      if (start) begin
        active <= 1'b1;
        cnt    <= '0;
        tx_sh  <= tx_words[SLOT_W-1:0];
      end else if (last || !active) begin
        active <= 1'b0;
        cnt    <= '0;
        tx_sh  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
        if (bit_idx == BIT_W'(SLOT_W-1)) tx_sh <= nxt_word;
        else                              tx_sh <= {tx_sh[SLOT_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sh    <= '0;
      rx_words <= '0;
    end else if (active) begin
      rx_sh <= {rx_sh[SLOT_W-3:0], sdi};
      if (bit_idx == BIT_W'(SLOT_W-1))
        rx_words[SLOT_W*int'(slot_idx) +: SLOT_W] <= {rx_sh, sdi};
    end
  end

  assign sdo        = tx_sh[SLOT_W-1];
  assign fsync      = active && (cnt == '0);
  assign frame_done = done_q;

  a_r3_sync_single: assert property (@(posedge clk) disable iff (!rst_n)
    fsync |=> !fsync);

  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  a_r2_max_chain: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && $past(sel_max)) |-> fsync);

  a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !sel_max && !tick_sel) |=> !active);

  a_r9_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !sdo);

  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !last) |=> (active && !fsync));

endmodule

// File: tb/tb_tdm_frame_seq.sv
`timescale 1ns/1ps
module tb_tdm_frame_seq;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [2:0]   rate_sel = 3'd0;
  logic [4:0]   rate_tick = '0;
  logic [191:0] tx_words = '0;
  logic         sdi = 1'b0;
  logic         sdo, fsync, frame_done;
  logic [191:0] rx_words;
  int total = 0;
  int bad = 0;

  tdm_frame_seq dut (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .rate_tick(rate_tick),
    .tx_words(tx_words), .sdi(sdi), .sdo(sdo), .fsync(fsync),
    .rx_words(rx_words), .frame_done(frame_done)
  );

  always #5 clk = ~clk;

  function automatic logic [191:0] make_words(input logic [15:0] base);
    logic [191:0] w;
    for (int s = 0; s < 12; s++)
      w[16*s +: 16] = base ^ (16'h1357 * 16'(s)) ^ {8'(s), 8'(~s)};
    return w;
  endfunction

  task automatic check(input string req, input logic [191:0] act,
                       input logic [191:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk); #3;
  endtask

  // Entered at +3 of the expected bit-0 clock; returns at +3 of the done clock.
  task automatic run_frame(input logic [15:0] rx_base, input int tick_at,
                           input int tick_idx);
    logic [191:0] rx_exp = make_words(rx_base);
    int sdo_err = 0, sync_err = 0, done_err = 0;
    check("R3 sync at frame start", 192'(fsync), 192'(1));
    for (int i = 0; i < 192; i++) begin
      if (i > 0) begin
        step();
        if (fsync !== 1'b0) sync_err++;
        if (frame_done !== 1'b0) done_err++;
      end
      if (tick_at >= 0) rate_tick[tick_idx] = (i == tick_at);
      if (sdo !== tx_words[16*(i/16) + 15 - (i%16)]) sdo_err++;
      sdi = rx_exp[16*(i/16) + 15 - (i%16)];
    end
    step();
    rate_tick = '0;
    check("R4 serial out bit errors", 192'(sdo_err), 192'(0));
    check("R3 sync single clock", 192'(sync_err), 192'(0));
    check("R5 done quiet mid frame", 192'(done_err), 192'(0));
    check("R5 done strobe", 192'(frame_done), 192'(1));
    check("R5 received words", rx_words, rx_exp);
  endtask

  task automatic idle_cycles(input int n, input string req);
    int err = 0;
    for (int i = 0; i < n; i++) begin
      step();
      if (fsync !== 1'b0 || sdo !== 1'b0) err++;
    end
    check(req, 192'(err), 192'(0));
  endtask

  task automatic test_reset;
    tx_words = make_words(16'hC35A);
    repeat (3) @(posedge clk);
    #3;
    check("R1 reset fsync", 192'(fsync), 192'(0));
    check("R1 reset sdo", 192'(sdo), 192'(0));
    check("R1 reset done", 192'(frame_done), 192'(0));
    check("R1 reset rx words", rx_words, 192'(0));
    @(negedge clk);
    rst_n = 1'b1;
    step();
    check("R1 first sync", 192'(fsync), 192'(1));
  endtask

  task automatic test_max_rate;
    run_frame(16'h9E21, -1, 0);
    check("R2 back to back sync", 192'(fsync), 192'(1));
    run_frame(16'h0F3C, -1, 0);
    check("R2 back to back sync", 192'(fsync), 192'(1));
  endtask

  task automatic test_tick_rate;
    rate_sel = 3'd1;
    run_frame(16'h7B44, 100, 0);
    check("R7 idle after frame", 192'(fsync), 192'(0));
    idle_cycles(20, "R9 R7 idle quiet");
    tx_words = make_words(16'h5A0F);
    rate_tick[2] = 1'b1;
    step();
    rate_tick = '0;
    check("R8 unselected tick ignored", 192'(fsync), 192'(0));
    idle_cycles(5, "R8 still idle");
    rate_tick[0] = 1'b1;
    step();
    rate_tick = '0;
    rate_sel = 3'd5;
    run_frame(16'hE817, 191, 4);
    check("R8 tick on last bit ignored", 192'(fsync), 192'(0));
    idle_cycles(7, "R9 idle after last bit tick");
    rate_tick[0] = 1'b1;
    step();
    rate_tick = '0;
    check("R6 old source ignored", 192'(fsync), 192'(0));
    rate_tick[4] = 1'b1;
    step();
    rate_tick = '0;
    check("R6 R7 aux0 tick starts frame", 192'(fsync), 192'(1));
  endtask

  task automatic test_reserved_sel;
    rate_sel = 3'd6;
    run_frame(16'h3311, -1, 0);
    check("R6 reserved select chains", 192'(fsync), 192'(1));
    rate_sel = 3'd0;
    run_frame(16'hBEEF, -1, 0);
    check("R2 max after reserved", 192'(fsync), 192'(1));
  endtask

  initial begin
    test_reset();
    test_max_rate();
    test_tick_rate();
    test_reserved_sel();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule